// File: doc/BRIEF.md
# Wide register write collector

This bus interface unit sits between a host register bus and an internal register file whose normal registers are 128 bits wide. A host may write such a register one 32-bit dword at a time, or as two 64-bit halves. The lower dwords are held in a staging buffer. The write that carries the top dword moves all 128 bits into the register in a single clock edge. The register therefore never holds a mix of old and new dwords.

Reads work the other way round. Reading dword 0 of a wide register returns its live value and, at the same edge, copies all 128 bits into a read shadow. Reads of dwords 1 to 3 are served from that shadow, so a host that reads dword 0 first sees one consistent value. A few 32-bit pointer-update registers commit at once and never touch the staging buffer, so they can be written between the dwords of a collection. A table of 64-bit entries collects its two dwords in the same way. The whole map repeats in pages of 0x2000 bytes.

The host port is valid/ready. A transfer takes place on a rising edge where `bus_valid` and `bus_ready` are both high. `bus_ready` is low during reset and high from the first edge after reset, so the block never applies back-pressure while running. The host must hold its request stable while `bus_valid` is high and `bus_ready` is low. Every accepted read produces exactly one response cycle, one edge later. The response cannot be stalled, so the host must accept it in that cycle.

Top module: `wreg_collector`

## Requirements
- R1: After reset, `bus_ready` is 1 one clock after `rst_n` rises, `collect_mismatch` is 0, and every register, table entry, staging word and shadow reads as zero.
- R2: A single-dword write to dword 0, 1 or 2 of a wide register (byte offset `idx*16 + lane*4` within a page, lane = dword number) changes only the staging buffer; the register keeps its old value.
- R3: A single-dword write to dword 3 writes the staged dwords 0 to 2 and the new dword 3 into the register as one 128-bit value, visible on the next read.
- R4: A 64-bit write (`bus_wide`=1, dword 0 in `bus_wdata[31:0]`) at byte offset 0 of a wide register stages dwords 0 and 1. A 64-bit write at byte offset 8 commits all 128 bits, taking dwords 2 and 3 from its data.
- R5: A read of dword 0 returns the live dword 0 and captures the whole register into the shadow. Reads of dwords 1 to 3 return the shadow, even if the register was rewritten after the capture.
- R6: Dword registers, at page offset `0x400 + j*16`, are updated by a single 32-bit write and read back at once.
- R7: A dword-register write made between dwords of a wide-register collection leaves the staged data intact, and the later commit stores the full collected value.
- R8: Table entries, at page offset `0x800 + k*8`, take a dword at +0 into a holding word and commit all 64 bits on the dword at +4. A 64-bit write at +0 commits the entry at once.
- R9: The byte address is `page*0x2000 + offset`. The same offset in different pages selects separate storage.
- R10: Wide and dword registers sit at a 16-byte stride per index. A dword-register access at +4, +8 or +12 within its slot is unmapped.
- R11: A dword-3 write (or a 64-bit write at offset 8) to a register other than the one last staged commits the staged dwords with the new data at the addressed register. It also sets `collect_mismatch`, which stays set until reset.
- R12: `rsp_valid` is 1 in exactly the cycle after an accepted read and 0 after a write. Unmapped addresses read as zero and ignore writes. Unmapped means a page at or above `PAGES`, an index past a region's size, offset bits 12 and up set, byte offset bits [1:0] nonzero, or region select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host request present |
| bus_ready | output | 1 | Block accepts a request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Write carries 64 bits (reads are always 32 bits) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data, lowest dword in bits [31:0] |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| collect_mismatch | output | 1 | Sticky: a commit did not match the staged register |

## Verification
The checker assumes the host never presents a request while `bus_ready` is low, and that every access is one transfer per accepted edge. It also assumes a 64-bit write is aimed only at an even dword of a wide register, or at the first dword of a table entry. The bench drives one transfer at a time on the falling edge and releases `bus_valid` one cycle later. Its 64-bit writes target only offsets 0 and 8 of wide registers and offset 0 of table entries. Mismatched commits are produced on purpose, and only after the checks that expect the flag to be clear.

// File: rtl/wcol_pkg.sv
package wcol_pkg;
  typedef enum logic [1:0] {
    RG_WIDE  = 2'd0,
    RG_DWORD = 2'd1,
    RG_TABLE = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [7:0] page;
    logic [7:0] index;
    logic [1:0] lane;
  } dec_t;
endpackage

// File: rtl/wcol_decode.sv
module wcol_decode
  import wcol_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_SHIFT  = 13,
  parameter int PAGES       = 2,
  parameter int WIDE_REGS   = 8,
  parameter int DW_REGS     = 4,
  parameter int TBL_ENTRIES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << PAGE_SHIFT) - 1);

  logic [ADDR_W-1:0] page_raw, off, slot16, slot8;

  always_comb begin
    page_raw   = addr >> PAGE_SHIFT;
    off        = addr & OFF_MASK;
    slot16     = (off >> 4) & ADDR_W'(63);
    slot8      = (off >> 3) & ADDR_W'(127);
    dec        = '0;
    dec.region = RG_NONE;
    dec.page   = 8'(page_raw);
    if (page_raw < ADDR_W'(PAGES) && (off >> 12) == '0 && off[1:0] == 2'b00) begin
      unique case (off[11:10])
        2'd0: if (slot16 < ADDR_W'(WIDE_REGS)) begin
          dec.region = RG_WIDE;
          dec.index  = 8'(slot16);
          dec.lane   = off[3:2];
        end
        2'd1: if (slot16 < ADDR_W'(DW_REGS) && off[3:2] == 2'b00) begin
          dec.region = RG_DWORD;
          dec.index  = 8'(slot16);
        end
        2'd2: if (slot8 < ADDR_W'(TBL_ENTRIES)) begin
          dec.region = RG_TABLE;
          dec.index  = 8'(slot8);
          dec.lane   = {1'b0, off[2]};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wcol_wide_bank.sv
module wcol_wide_bank #(
  parameter int PAGES     = 2,
  parameter int WIDE_REGS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_wide,
  input  logic                           rd_en,
  input  logic [7:0]                     page,
  input  logic [7:0]                     index,
  input  logic [1:0]                     lane,
  input  logic [63:0]                    wdata,
  output logic [31:0]                    rd_dword,
  output logic                           mismatch,
  output logic [PAGES*WIDE_REGS*128-1:0] file_flat,
  output logic [95:0]                    stage_flat
);
  localparam int NREG = PAGES * WIDE_REGS;
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [127:0]  file_q [NREG];
  logic [95:0]   stage_q;
  logic [127:0]  shadow_q;
  logic [IW-1:0] tag_q;
  logic [IW-1:0] slot;
  logic          mism_q;

  assign slot = IW'(32'(page) * WIDE_REGS + 32'(index));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) file_q[i] <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
      tag_q    <= '0;
      mism_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        if (!wr_wide) begin
          if (lane == 2'd3) begin
            file_q[slot] <= {wdata[31:0], stage_q};
            if (tag_q != slot) mism_q <= 1'b1;
          end else begin
            stage_q[lane*32 +: 32] <= wdata[31:0];
            tag_q <= slot;
          end
        end else if (lane == 2'd0) begin
          stage_q[63:0] <= wdata;
          tag_q <= slot;
        end else if (lane == 2'd2) begin
          file_q[slot] <= {wdata, stage_q[63:0]};
          if (tag_q != slot) mism_q <= 1'b1;
        end
      end
      if (rd_en && lane == 2'd0) shadow_q <= file_q[slot];
    end
  end

  assign rd_dword   = (lane == 2'd0) ? file_q[slot][31:0] : shadow_q[lane*32 +: 32];
  assign mismatch   = mism_q;
  assign stage_flat = stage_q;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign file_flat[g*128 +: 128] = file_q[g];
  end
endmodule

// File: rtl/wcol_dword_bank.sv
module wcol_dword_bank #(
  parameter int PAGES   = 2,
  parameter int DW_REGS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  page,
  input  logic [7:0]  index,
  input  logic [31:0] wdata,
  output logic [31:0] rd_dword
);
  localparam int NREG = PAGES * DW_REGS;
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0]   regs_q [NREG];
  logic [IW-1:0] slot;

  assign slot = IW'(32'(page) * DW_REGS + 32'(index));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[slot] <= wdata;
    end
  end

  assign rd_dword = regs_q[slot];
endmodule

// File: rtl/wcol_table_bank.sv
module wcol_table_bank #(
  parameter int PAGES       = 2,
  parameter int TBL_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [7:0]  page,
  input  logic [7:0]  index,
  input  logic        half,
  input  logic [63:0] wdata,
  output logic [31:0] rd_dword
);
  localparam int NENT = PAGES * TBL_ENTRIES;
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1;

  logic [63:0]   ent_q [NENT];
  logic [31:0]   hold_q;
  logic [IW-1:0] slot;

  assign slot = IW'(32'(page) * TBL_ENTRIES + 32'(index));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= '0;
      hold_q <= '0;
    end else if (wr_en) begin
      if (wr_wide) begin
        if (!half) ent_q[slot] <= wdata;
      end else if (!half) begin
        hold_q <= wdata[31:0];
      end else begin
        ent_q[slot] <= {wdata[31:0], hold_q};
      end
    end
  end

  assign rd_dword = half ? ent_q[slot][63:32] : ent_q[slot][31:0];
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector
  import wcol_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_SHIFT  = 13,
  parameter int PAGES       = 2,
  parameter int WIDE_REGS   = 8,
  parameter int DW_REGS     = 4,
  parameter int TBL_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              collect_mismatch
);
  localparam int FW = PAGES * WIDE_REGS * 128;

  dec_t        dec;
  logic        ready_q, acc, acc_wr, acc_rd;
  logic [31:0] wide_rd, dw_rd, tb_rd, rd_mux;
  logic        rsp_valid_q;
  logic [31:0] rsp_data_q;
  logic [FW-1:0] wide_file_flat;
  logic [95:0]   stage_flat;

  wcol_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGES(PAGES),
    .WIDE_REGS(WIDE_REGS), .DW_REGS(DW_REGS), .TBL_ENTRIES(TBL_ENTRIES)
  ) u_dec (
    .addr(bus_addr),
    .dec (dec)
  );

  assign acc    = bus_valid && ready_q;
  assign acc_wr = acc && bus_write;
  assign acc_rd = acc && !bus_write;

  wcol_wide_bank #(.PAGES(PAGES), .WIDE_REGS(WIDE_REGS)) u_wide (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (acc_wr && dec.region == RG_WIDE),
    .wr_wide   (bus_wide),
    .rd_en     (acc_rd && dec.region == RG_WIDE),
    .page      (dec.page),
    .index     (dec.index),
    .lane      (dec.lane),
    .wdata     (bus_wdata),
    .rd_dword  (wide_rd),
    .mismatch  (collect_mismatch),
    .file_flat (wide_file_flat),
    .stage_flat(stage_flat)
  );

  wcol_dword_bank #(.PAGES(PAGES), .DW_REGS(DW_REGS)) u_dw (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr && dec.region == RG_DWORD),
    .page    (dec.page),
    .index   (dec.index),
    .wdata   (bus_wdata[31:0]),
    .rd_dword(dw_rd)
  );

  wcol_table_bank #(.PAGES(PAGES), .TBL_ENTRIES(TBL_ENTRIES)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr && dec.region == RG_TABLE),
    .wr_wide (bus_wide),
    .page    (dec.page),
    .index   (dec.index),
    .half    (dec.lane[0]),
    .wdata   (bus_wdata),
    .rd_dword(tb_rd)
  );

  always_comb begin
    unique case (dec.region)
      RG_WIDE:  rd_mux = wide_rd;
      RG_DWORD: rd_mux = dw_rd;
      RG_TABLE: rd_mux = tb_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= acc_rd;
      if (acc_rd) rsp_data_q <= rd_mux;
    end
  end

  assign bus_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/wcol_checker.sv
module wcol_checker
  import wcol_pkg::*;
#(
  parameter int FW = 2048
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc,
  input logic          bus_write,
  input logic          bus_wide,
  input region_e       region,
  input logic [1:0]    lane,
  input logic          rsp_valid,
  input logic          collect_mismatch,
  input logic [FW-1:0] wide_file,
  input logic [95:0]   stage
);
  // R12: a response appears only after an accepted read
  p_rsp_follows_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && !bus_write));

  // R2: lower-dword writes leave the register file untouched
  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_write && !bus_wide && region == RG_WIDE && lane != 2'd3)
      |=> $stable(wide_file));

  // R4: a low 64-bit half only stages
  p_low_half_stages_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_write && bus_wide && region == RG_WIDE && lane == 2'd0)
      |=> $stable(wide_file));

  // R7: dword-register writes disturb neither staging nor wide registers
  p_dword_keeps_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_write && region == RG_DWORD) |=> ($stable(stage) && $stable(wide_file)));

  // R5: reads never modify the wide registers
  p_read_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bus_write) |=> $stable(wide_file));

  // R11: the mismatch flag is sticky
  p_mismatch_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    collect_mismatch |=> collect_mismatch);
endmodule

bind wreg_collector wcol_checker #(.FW(PAGES * WIDE_REGS * 128)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .acc             (acc),
  .bus_write       (bus_write),
  .bus_wide        (bus_wide),
  .region          (dec.region),
  .lane            (dec.lane),
  .rsp_valid       (rsp_valid),
  .collect_mismatch(collect_mismatch),
  .wide_file       (wide_file_flat),
  .stage           (stage_flat)
);

// File: tb/sim_wreg_collector.sv
module sim_wreg_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, collect_mismatch;
  logic [31:0] rsp_data;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  wreg_collector u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .collect_mismatch(collect_mismatch)
  );

  function automatic logic [15:0] wa(int p, int i, int d);
    return 16'(p * 32'h2000 + i * 16 + d * 4);
  endfunction
  function automatic logic [15:0] da(int p, int j);
    return 16'(p * 32'h2000 + 32'h400 + j * 16);
  endfunction
  function automatic logic [15:0] ta(int p, int k, int h);
    return 16'(p * 32'h2000 + 32'h800 + k * 8 + h * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr32(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wide = 1'b0; bus_addr = a; bus_wdata = {32'h0, d};
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr64(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wide = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R12 rsp_valid after read", 32'(rsp_valid), 32'd1);
    v = rsp_data;
  endtask

  task automatic chk_wide(string req, int p, int i, logic [127:0] exp);
    logic [31:0] v;
    for (int d = 0; d < 4; d++) begin
      rd(wa(p, i, d), v);
      chk(req, v, exp[d*32 +: 32]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 ready", 32'(bus_ready), 32'd1);
    chk("R1 mismatch", 32'(collect_mismatch), 32'd0);
    chk_wide("R1 wide zero", 0, 0, 128'h0);
    rd(da(0, 0), v); chk("R1 dword zero", v, 32'h0);
    rd(ta(0, 0, 1), v); chk("R1 table zero", v, 32'h0);
  endtask

  task automatic t_collect;
    logic [31:0] v;
    wr32(wa(0, 2, 0), 32'hA0A0_0001);
    wr32(wa(0, 2, 1), 32'hA0A0_0002);
    wr32(wa(0, 2, 2), 32'hA0A0_0003);
    rd(wa(0, 2, 0), v); chk("R2 no partial update", v, 32'h0);
    chk_wide("R2 staged only", 0, 2, 128'h0);
    wr32(wa(0, 2, 3), 32'hA0A0_0004);
    chk_wide("R3 commit", 0, 2, {32'hA0A0_0004, 32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001});
  endtask

  task automatic t_halves;
    wr64(wa(0, 3, 0), {32'hB000_0002, 32'hB000_0001});
    chk_wide("R4 low half stages", 0, 3, 128'h0);
    wr64(wa(0, 3, 2), {32'hB000_0004, 32'hB000_0003});
    chk_wide("R4 high half commits", 0, 3,
             {32'hB000_0004, 32'hB000_0003, 32'hB000_0002, 32'hB000_0001});
  endtask

  task automatic t_snapshot;
    logic [31:0] v;
    for (int d = 0; d < 4; d++) wr32(wa(0, 4, d), 32'hC100_0000 + 32'(d));
    rd(wa(0, 4, 0), v); chk("R5 live dword0", v, 32'hC100_0000);
    for (int d = 0; d < 4; d++) wr32(wa(0, 4, d), 32'hD200_0000 + 32'(d));
    for (int d = 1; d < 4; d++) begin
      rd(wa(0, 4, d), v); chk("R5 shadow held", v, 32'hC100_0000 + 32'(d));
    end
    rd(wa(0, 4, 0), v); chk("R5 new dword0", v, 32'hD200_0000);
    rd(wa(0, 4, 2), v); chk("R5 new snapshot", v, 32'hD200_0002);
  endtask

  task automatic t_dword_mid;
    logic [31:0] v;
    wr32(wa(0, 5, 0), 32'hE000_0001);
    wr32(wa(0, 5, 1), 32'hE000_0002);
    wr32(da(0, 1), 32'h1234_5678);
    wr32(wa(0, 5, 2), 32'hE000_0003);
    wr32(wa(0, 5, 3), 32'hE000_0004);
    chk_wide("R7 collection intact", 0, 5,
             {32'hE000_0004, 32'hE000_0003, 32'hE000_0002, 32'hE000_0001});
    rd(da(0, 1), v); chk("R6 dword reg", v, 32'h1234_5678);
    chk("R7 no mismatch", 32'(collect_mismatch), 32'd0);
  endtask

  task automatic t_stride;
    logic [31:0] v;
    wr32(da(0, 2), 32'h2222_2222);
    wr32(da(0, 3), 32'h3333_3333);
    wr32(da(0, 2) + 16'h4, 32'hDEAD_BEEF);
    rd(da(0, 2), v); chk("R10 slot 2", v, 32'h2222_2222);
    rd(da(0, 3), v); chk("R10 slot 3", v, 32'h3333_3333);
    rd(da(0, 2) + 16'h4, v); chk("R10 +4 unmapped", v, 32'h0);
  endtask

  task automatic t_table;
    logic [31:0] v;
    wr32(ta(0, 2, 0), 32'h5555_0000);
    rd(ta(0, 2, 0), v); chk("R8 low held", v, 32'h0);
    wr32(ta(0, 2, 1), 32'h5555_1111);
    rd(ta(0, 2, 0), v); chk("R8 low commit", v, 32'h5555_0000);
    rd(ta(0, 2, 1), v); chk("R8 high commit", v, 32'h5555_1111);
    wr64(ta(0, 3, 0), 64'h6666_1111_6666_0000);
    rd(ta(0, 3, 0), v); chk("R8 64-bit low", v, 32'h6666_0000);
    rd(ta(0, 3, 1), v); chk("R8 64-bit high", v, 32'h6666_1111);
  endtask

  task automatic t_page;
    logic [31:0] v;
    for (int d = 0; d < 4; d++) wr32(wa(1, 2, d), 32'hF100_0000 + 32'(d));
    chk_wide("R9 page1", 1, 2, {32'hF100_0003, 32'hF100_0002, 32'hF100_0001, 32'hF100_0000});
    rd(wa(0, 2, 0), v); chk("R9 page0 untouched", v, 32'hA0A0_0001);
    wr32(da(1, 1), 32'h7777_0001);
    rd(da(0, 1), v); chk("R9 dword page0", v, 32'h1234_5678);
    rd(da(1, 1), v); chk("R9 dword page1", v, 32'h7777_0001);
  endtask

  task automatic t_mismatch;
    chk("R11 clear before", 32'(collect_mismatch), 32'd0);
    wr32(wa(0, 6, 0), 32'h9000_0000);
    wr32(wa(0, 6, 1), 32'h9000_0001);
    wr32(wa(0, 6, 2), 32'h9000_0002);
    wr32(wa(0, 1, 3), 32'h9000_0003);
    chk("R11 flag set", 32'(collect_mismatch), 32'd1);
    chk_wide("R11 commit at dword3 reg", 0, 1,
             {32'h9000_0003, 32'h9000_0002, 32'h9000_0001, 32'h9000_0000});
    chk_wide("R11 staged reg untouched", 0, 6, 128'h0);
    for (int d = 0; d < 4; d++) wr32(wa(0, 7, d), 32'h8000_0000 + 32'(d));
    chk("R11 flag sticky", 32'(collect_mismatch), 32'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr32(16'h4000, 32'hABCD_0001);
    chk("R12 no rsp after write", 32'(rsp_valid), 32'd0);
    rd(16'h4000, v); chk("R12 bad page reads 0", v, 32'h0);
    wr32(wa(0, 8, 0), 32'hABCD_0002);
    rd(wa(0, 8, 0), v); chk("R12 bad index reads 0", v, 32'h0);
    rd(16'h0C00, v); chk("R12 region 3 reads 0", v, 32'h0);
    rd(da(0, 0), v); chk("R12 dword 0 unaffected", v, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_collect();
    t_halves();
    t_snapshot();
    t_dword_mid();
    t_stride();
    t_table();
    t_page();
    t_mismatch();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule